// File: doc/BRIEF.md
# Reset and Wake-Up Sequencer

This block produces the chip-wide internal reset and the processor run enable. Two things can request a reset: the external reset pin, which passes through a synchroniser and a glitch filter, and a request from the watchdog, which is latched so that a single-cycle pulse is enough. After any reset, the internal reset is released only when four conditions are all true. The pin must be released, the oscillator must report itself valid, a fixed number of oscillator clocks must have elapsed, and the on-chip initialisation logic must report that it is done.

The same settle timer is used when the chip leaves power-down. The oscillator is stopped in that mode, so it has to prove itself stable again before the processor runs. A power-down request from the running state parks the processor and keeps the internal reset released. A wake event then runs the oscillator check, the settle count and the initialisation check. The internal reset stays released throughout, and the run enable stays low until the sequence finishes. A reset from either source also ends power-down.

Top module: `rwu_seq`

## Requirements
- R1: While the power-on reset `rst_n` is low, `chip_rst_n` and `cpu_run` are both 0.
- R2: A low pulse on `ext_rst_pin_n` that lasts fewer than FILT_LEN clock samples has no effect. `chip_rst_n` and `cpu_run` stay 1.
- R3: A low level on `ext_rst_pin_n` that lasts at least FILT_LEN samples drives `chip_rst_n` and `cpu_run` to 0. They stay at 0 for as long as the pin is held low.
- R4: After the pin is released, with `osc_ok` and `init_done` high, `chip_rst_n` and `cpu_run` rise together on the clock edge WAKE_CYC+FILT_LEN+5 edges after the first edge that samples the released pin. The same timing applies when leaving power-on reset with the pin high. `cpu_run` is never 1 while `chip_rst_n` is 0.
- R5: A single-cycle `wdt_req` pulse drives `chip_rst_n` to 0 on the second edge, counting the edge that samples the pulse as the first. With `osc_ok` and `init_done` high, the run resumes on edge WAKE_CYC+6.
- R6: The settle count needs WAKE_CYC consecutive cycles with `osc_ok` high. A drop of `osc_ok` during the count restarts it from zero once `osc_ok` returns.
- R7: `cpu_run` rises only after `init_done` has been sampled high. If the settle count has finished, `cpu_run` rises on the first edge that samples `init_done` high.
- R8: `pd_enter`, when sampled in the run state, clears `cpu_run` on that edge and keeps `chip_rst_n` at 1 for the whole of power-down.
- R9: `wake_evt` in power-down restarts the sequence at the oscillator check without asserting `chip_rst_n`. With `osc_ok` and `init_done` high, `cpu_run` rises WAKE_CYC+3 edges after the edge that samples the wake.
- R10: A `wdt_req` pulse in power-down leaves power-down through a full reset sequence with the timing of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the sequencer itself |
| ext_rst_pin_n | input | 1 | Raw external reset pin, active low, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, may be a one-cycle pulse |
| osc_ok | input | 1 | Oscillator reported stable |
| pd_enter | input | 1 | Request to enter power-down, honoured in the run state |
| wake_evt | input | 1 | Wake event from power-down |
| init_done | input | 1 | On-chip initialisation complete |
| chip_rst_n | output | 1 | Internal chip reset, active low |
| cpu_run | output | 1 | Processor run enable |

## Verification
The bench builds the block with FILT_LEN = 4 and WAKE_CYC = 16. With a settle count that short, every release path can be timed to the exact edge. These paths are power-on, pin, watchdog, wake, watchdog from power-down, and the restart after an oscillator drop. The expected edge counts come from the formulas in R4, R5, R6 and R9. A filter length of 4 lets the bench sweep pin pulse lengths from 1 to 6 cycles, which covers both sides of the acceptance threshold.

// File: rtl/rwu_pkg.sv
// Shared types for the reset and wake-up sequencer.
package rwu_pkg;

    // Sequencer states; SEQ_HOLD is the reset state.
    typedef enum logic [2:0] {
        SEQ_HOLD      = 3'd0,
        SEQ_OSC_WAIT  = 3'd1,
        SEQ_SETTLE    = 3'd2,
        SEQ_INIT_WAIT = 3'd3,
        SEQ_RUN       = 3'd4,
        SEQ_SLEEP     = 3'd5
    } seq_state_e;

endpackage

// File: rtl/rwu_pin_filter.sv
// Synchronises the raw reset pin and accepts a level change only after
// FILT_LEN consecutive samples of the new level.
// Assumes FILT_LEN >= 2. Under rst_n both the synchroniser and the filtered
// level read low, meaning "pin asserted".
module rwu_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_asserted
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic          sync1_q, sync2_q;
    logic          lvl_q;
    logic [CW-1:0] cnt_q;

    // Two-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin_n;
            sync2_q <= sync1_q;
        end
    end

    // Counts consecutive samples that differ from the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (sync2_q == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            lvl_q <= sync2_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pin_asserted = !lvl_q;

    // R2: the accepted level moves only after a full run of differing samples.
    p_filter_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(cnt_q) == CNT_LAST);

endmodule

// File: rtl/rwu_settle_counter.sv
// Counts oscillator cycles while enabled and flags the last one.
// Assumes the clear input is high whenever counting is not allowed, so that
// each settle period starts from zero.
module rwu_settle_counter #(
    parameter int WAKE_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Settle counter: restarts on clear, advances while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = en && (cnt_q == CNT_LAST);

    // R6: a clear always restarts the count from zero.
    p_settle_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

    // R6: the count never runs past the last settle cycle.
    p_settle_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

endmodule

// File: rtl/rwu_seq.sv
// Reset and wake-up sequencer top. Combines the filtered pin and a latched
// watchdog request into the reset condition. The state machine walks the
// oscillator check, the settle count and the initialisation check before it
// releases the chip and starts the processor. A power-down wake runs the same
// walk but leaves the internal reset released.
// Assumes clk is the oscillator clock and rst_n is a clean synchronous
// power-on reset.
module rwu_seq
    import rwu_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int WAKE_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst_pin_n,
    input  logic wdt_req,
    input  logic osc_ok,
    input  logic pd_enter,
    input  logic wake_evt,
    input  logic init_done,
    output logic chip_rst_n,
    output logic cpu_run
);

    seq_state_e state_q, state_d;
    logic       pin_asserted;
    logic       wdt_pend_q;
    logic       reset_req;
    logic       settle_en, settle_done;
    logic       rst_rel_q;

    rwu_pin_filter #(.FILT_LEN(FILT_LEN)) i_pin_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_n        (ext_rst_pin_n),
        .pin_asserted (pin_asserted)
    );

    rwu_settle_counter #(.WAKE_CYC(WAKE_CYC)) i_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!settle_en),
        .en    (settle_en),
        .done  (settle_done)
    );

    // Holds a watchdog request until the sequencer sits in the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_pend_q <= 1'b0;
        end else if (wdt_req) begin
            wdt_pend_q <= 1'b1;
        end else if (state_q == SEQ_HOLD) begin
            wdt_pend_q <= 1'b0;
        end
    end

    assign reset_req = pin_asserted || wdt_pend_q;
    assign settle_en = (state_q == SEQ_SETTLE) && osc_ok;

    // Next-state logic; a reset request from either source overrides all.
    always_comb begin
        state_d = state_q;
        if (reset_req) begin
            state_d = SEQ_HOLD;
        end else begin
            case (state_q)
                SEQ_HOLD:      state_d = SEQ_OSC_WAIT;
                SEQ_OSC_WAIT:  if (osc_ok) state_d = SEQ_SETTLE;
                SEQ_SETTLE: begin
                    if (!osc_ok)          state_d = SEQ_OSC_WAIT;
                    else if (settle_done) state_d = SEQ_INIT_WAIT;
                end
                SEQ_INIT_WAIT: if (init_done) state_d = SEQ_RUN;
                SEQ_RUN:       if (pd_enter)  state_d = SEQ_SLEEP;
                SEQ_SLEEP:     if (wake_evt)  state_d = SEQ_OSC_WAIT;
                default:       state_d = SEQ_HOLD;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_HOLD;
        else        state_q <= state_d;
    end

    // Internal reset: asserted on entry to hold, released on entry to run.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rst_rel_q <= 1'b0;
        else if (state_d == SEQ_HOLD)   rst_rel_q <= 1'b0;
        else if (state_d == SEQ_RUN)    rst_rel_q <= 1'b1;
    end

    assign chip_rst_n = rst_rel_q;
    assign cpu_run    = (state_q == SEQ_RUN);

    // R4: the processor never runs while the chip is held in reset.
    p_run_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> chip_rst_n);

    // R5: a watchdog pulse reaches the internal reset two edges later.
    p_wdt_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |-> ##2 !chip_rst_n);

    // R7: the run starts only after initialisation was reported done.
    p_run_after_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> $past(init_done));

    // R8: power-down keeps the internal reset released.
    p_sleep_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SLEEP) |-> chip_rst_n);

    // R9: a wake does not assert the internal reset.
    p_wake_no_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == SEQ_SLEEP && state_q == SEQ_OSC_WAIT) |-> chip_rst_n);

endmodule

// File: tb/test_rwu_seq.sv
module test_rwu_seq;

    localparam int F = 4;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n, pin_n, wdt_req, osc_ok, pd_enter, wake_evt, init_done;
    logic chip_rst_n, cpu_run;
    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    logic saw_rst, saw_stop;

    always #2.5 clk = ~clk;

    rwu_seq #(.FILT_LEN(F), .WAKE_CYC(W)) i_rwu_seq (
        .clk(clk), .rst_n(rst_n), .ext_rst_pin_n(pin_n), .wdt_req(wdt_req),
        .osc_ok(osc_ok), .pd_enter(pd_enter), .wake_evt(wake_evt),
        .init_done(init_done), .chip_rst_n(chip_rst_n), .cpu_run(cpu_run)
    );

    always @(negedge clk) begin
        if (!chip_rst_n) saw_rst  = 1'b1;
        if (!cpu_run)    saw_stop = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 100000);
            finish_run();
        end
    end

    // Counts edges until cpu_run is seen high, starting from a given count.
    task automatic wait_run(input int start, output int n);
        n = start;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!cpu_run && n < 1000);
    endtask

    task automatic wdt_pulse(output int n);
        @(negedge clk) wdt_req = 1'b1;
        @(posedge clk);
        @(negedge clk) wdt_req = 1'b0;
        check(chip_rst_n == 1'b1, "R5 edge1", chip_rst_n, 1);
        @(posedge clk);
        @(negedge clk);
        check(chip_rst_n == 1'b0, "R5 edge2", chip_rst_n, 0);
        wait_run(2, n);
    endtask

    task automatic enter_pd();
        @(negedge clk) pd_enter = 1'b1;
        @(posedge clk);
        @(negedge clk) pd_enter = 1'b0;
        check(cpu_run == 1'b0, "R8 run", cpu_run, 0);
        check(chip_rst_n == 1'b1, "R8 rst", chip_rst_n, 1);
    endtask

    task automatic wake_pulse();
        @(negedge clk) wake_evt = 1'b1;
        @(posedge clk);
        @(negedge clk) wake_evt = 1'b0;
    endtask

    initial begin
        int n;
        rst_n = 1'b0; pin_n = 1'b1; wdt_req = 1'b0; osc_ok = 1'b1;
        pd_enter = 1'b0; wake_evt = 1'b0; init_done = 1'b1;
        repeat (4) @(negedge clk);
        check(chip_rst_n == 1'b0, "R1 rst", chip_rst_n, 0);
        check(cpu_run == 1'b0, "R1 run", cpu_run, 0);
        rst_n = 1'b1;
        wait_run(0, n);
        check(n == W + F + 5, "R4 power-on", n, W + F + 5);
        check(chip_rst_n == 1'b1, "R4 release", chip_rst_n, 1);

        // R2 short pulses ignored, R3 long pulses accepted
        for (int len = 1; len <= 6; len++) begin
            @(negedge clk);
            saw_rst = 1'b0; saw_stop = 1'b0;
            pin_n = 1'b0;
            repeat (len) @(negedge clk);
            pin_n = 1'b1;
            repeat (12) @(negedge clk);
            if (len < F) begin
                check(!saw_rst, "R2 rst", saw_rst, 0);
                check(!saw_stop, "R2 run", saw_stop, 0);
            end else begin
                check(saw_rst, "R3 pulse", saw_rst, 1);
                if (!cpu_run) wait_run(0, n);
                check(cpu_run == 1'b1, "R3 recover", cpu_run, 1);
            end
        end

        // R3 hold while pin low, R4 release timing
        @(negedge clk) pin_n = 1'b0;
        repeat (50) @(negedge clk);
        check(chip_rst_n == 1'b0, "R3 held rst", chip_rst_n, 0);
        check(cpu_run == 1'b0, "R3 held run", cpu_run, 0);
        pin_n = 1'b1;
        wait_run(0, n);
        check(n == W + F + 5, "R4 pin release", n, W + F + 5);

        // R5 watchdog pulse
        wdt_pulse(n);
        check(n == W + 6, "R5 timing", n, W + 6);

        // R8 then R6 restart on oscillator drop during the wake
        enter_pd();
        osc_ok = 1'b0;
        saw_rst = 1'b0;
        wake_pulse();
        repeat (10) @(negedge clk);
        check(cpu_run == 1'b0, "R6 osc wait", cpu_run, 0);
        osc_ok = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) osc_ok = 1'b0;
        @(posedge clk);
        @(negedge clk) osc_ok = 1'b1;
        wait_run(6, n);
        check(n == W + 8, "R6 restart", n, W + 8);
        check(!saw_rst, "R9 no reset", saw_rst, 0);

        // R9 plain wake
        enter_pd();
        repeat (5) @(negedge clk);
        check(cpu_run == 1'b0 && chip_rst_n == 1'b1, "R8 sleep", cpu_run, 0);
        wake_pulse();
        wait_run(1, n);
        check(n == W + 3, "R9 timing", n, W + 3);

        // R7 initialisation gating
        enter_pd();
        init_done = 1'b0;
        wake_pulse();
        repeat (W + 10) @(negedge clk);
        check(cpu_run == 1'b0, "R7 gate", cpu_run, 0);
        init_done = 1'b1;
        wait_run(0, n);
        check(n == 1, "R7 release", n, 1);

        // R10 watchdog from power-down
        enter_pd();
        wdt_pulse(n);
        check(n == W + 6, "R10 timing", n, W + 6);

        finish_run();
    end

endmodule